// File: doc/BRIEF.md
# SCSI Synchronous Transfer Clock Divider

This block turns one input clock into the timing enables that a parallel SCSI data path needs. It contains three programmable dividers. A core divider paces the asynchronous control logic. A synchronous prescaler paces the synchronous transfer logic. A transfer-period divider counts prescaler ticks and so sets the send period. A fixed divide-by-four tap on the prescaler ticks gives the maximum synchronous receive rate.

Every output is a single-clock enable in the input clock domain, so no derived clocks exist. A combinational error flag reports a prescaler setting that is reserved or that would push the prescaler output above 50 MHz, given the input frequency declared in the parameter `CLK_KHZ`. When a divider field changes, the new value is taken up only at the next terminal count of that divider. A pulse train therefore never has a gap that is shorter than either the old period or the new one.

Top module: `xfer_clk_div`

## Requirements
- R1: `core_en` pulses once every `core_fac`+1 clocks. The value 0 gives a pulse on every clock and the value 7 gives a pulse on every eighth clock.
- R2: `pre_en` is paced by `sync_fac` as follows: 0 → every clock, 2 → every 2nd clock, 3 → every 3rd clock, 4 → every 4th clock, 5 → every 6th clock. Code 1 means divide by 1.5: the gaps between pulses alternate 2, 1, 2, 1 clocks, starting with 2 after reset.
- R3: `sync_fac` codes 6 and 7 are reserved. While one of them is in use, `pre_en`, `rx_en` and `tx_en` never pulse.
- R4: `rx_en` is high together with every fourth `pre_en` pulse and is low at all other times.
- R5: `tx_en` is high together with every (`period_sel`+4)th `pre_en` pulse. This gives a send period of 4 to 11 prescaler ticks.
- R6: With a 40 MHz clock, prescale ÷2 with `period_sel`=0 and prescale ÷1 with `period_sel`=4 both give a `tx_en` pulse every 8 clocks, which is 5 MHz.
- R7: `cfg_err` is high in the same cycle when `sync_fac` holds a reserved code, or when `CLK_KHZ` divided by the selected prescale exceeds 50000 kHz. Otherwise it is low.
- R8: A changed divider field takes effect only after the current period of that divider completes. The pulse that ends the old period comes on time, and the new spacing applies from then on.
- R9: While `rst` is high, every enable is low. After release, the first pulse of each enable appears only when a full period has elapsed.
- R10: The `core_en` timing does not depend on `sync_fac` or `period_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| core_fac | input | 3 | Core divider field, divide by value+1 |
| sync_fac | input | 3 | Prescaler field |
| period_sel | input | 3 | Transfer period field, value+4 prescaler ticks |
| core_en | output | 1 | Asynchronous core enable |
| pre_en | output | 1 | Prescaler tick |
| rx_en | output | 1 | Receive-rate strobe |
| tx_en | output | 1 | Send-period strobe |
| cfg_err | output | 1 | Prescaler setting reserved or too fast |

## Verification
`core_en` and `pre_en` are registered. Each is high in the clock that follows the edge completing its count, so edge k after reset release yields a pulse for every k that is a multiple of the period. `rx_en` and `tx_en` are high in the same cycle as the `pre_en` they qualify, and `cfg_err` follows `sync_fac` combinationally. The bench numbers the edges from reset release and samples every output at the falling edge after edge k. It predicts each output from the prescaler tick count up to edge k, computed arithmetically. For the reload cases, the field is changed mid-period and the bench checks the exact edges where the old terminal pulse and the new spacing fall.

// File: rtl/xfer_clk_div.sv
module xfer_clk_div #(
  parameter int unsigned CLK_KHZ     = 40000,
  parameter int unsigned MAX_PRE_KHZ = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] core_fac,
  input  logic [2:0] sync_fac,
  input  logic [2:0] period_sel,
  output logic       core_en,
  output logic       pre_en,
  output logic       rx_en,
  output logic       tx_en,
  output logic       cfg_err
);

  logic [2:0] ccnt, core_q;
  logic [2:0] pcnt, pre_q, pre_last;
  logic       phase;
  logic [3:0] tcnt;
  logic [2:0] per_q;
  logic [1:0] rcnt;

  wire pre_ok   = (pre_q < 3'd6);
  wire pre_term = (pcnt == pre_last);

  always_comb begin
    case (pre_q)
      3'd0:    pre_last = 3'd0;
      3'd1:    pre_last = phase ? 3'd0 : 3'd1;
      3'd2:    pre_last = 3'd1;
      3'd3:    pre_last = 3'd2;
      3'd4:    pre_last = 3'd3;
      default: pre_last = 3'd5;
    endcase
  end

  // twice the prescale, so the divide by 1.5 stays an integer
  int unsigned half2;
  always_comb begin
    case (sync_fac)
      3'd0:    half2 = 2;
      3'd1:    half2 = 3;
      3'd2:    half2 = 4;
      3'd3:    half2 = 6;
      3'd4:    half2 = 8;
      default: half2 = 12;
    endcase
    cfg_err = (sync_fac > 3'd5) || (CLK_KHZ * 2 > MAX_PRE_KHZ * half2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccnt <= '0; core_q <= core_fac; core_en <= 1'b0;
    end else if (ccnt == core_q) begin
      ccnt <= '0; core_q <= core_fac; core_en <= 1'b1;
    end else begin
      ccnt <= ccnt + 3'd1; core_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0; pre_q <= sync_fac; phase <= 1'b0; pre_en <= 1'b0;
    end else if (pre_term) begin
      pcnt   <= '0;
      pre_q  <= sync_fac;
      phase  <= (pre_q == 3'd1 && sync_fac == 3'd1) ? ~phase : 1'b0;
      pre_en <= pre_ok;
    end else begin
      pcnt <= pcnt + 3'd1; pre_en <= 1'b0;
    end
  end

  assign tx_en = pre_en && (tcnt == ({1'b0, per_q} + 4'd3));
  assign rx_en = pre_en && (rcnt == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0; per_q <= period_sel; rcnt <= '0;
    end else if (pre_en) begin
      rcnt <= rcnt + 2'd1;
      if (tx_en) begin
        tcnt <= '0; per_q <= period_sel;
      end else begin
        tcnt <= tcnt + 4'd1;
      end
    end
  end

  assert_rst_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !core_en && !pre_en && !tx_en && !rx_en);

  assert_pre_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    pre_en && $past(pre_en) |-> $past(pre_q) <= 3'd1);

  assert_tx_gap_R5: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> !tx_en);

  assert_rx_gap_R4: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> !rx_en);

  assert_core_reload_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(core_q) && !$past(rst) |-> core_en);

endmodule

// File: tb/xfer_clk_div_tb_top.sv
module xfer_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] core_fac = '0, sync_fac = '0, period_sel = '0;
  logic core_en, pre_en, rx_en, tx_en, cfg_err;
  logic h_core, h_pre, h_rx, h_tx, h_err;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_clk_div #(.CLK_KHZ(40000)) dut_i (
    .clk, .rst, .core_fac, .sync_fac, .period_sel,
    .core_en, .pre_en, .rx_en, .tx_en, .cfg_err);

  xfer_clk_div #(.CLK_KHZ(80000)) dut_hi_i (
    .clk, .rst, .core_fac, .sync_fac, .period_sel,
    .core_en(h_core), .pre_en(h_pre), .rx_en(h_rx), .tx_en(h_tx), .cfg_err(h_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pre_ticks(int code, int k);
    case (code)
      0: return k;
      1: return (k / 3) * 2 + ((k % 3) == 2 ? 1 : 0);
      2: return k / 2;
      3: return k / 3;
      4: return k / 4;
      5: return k / 6;
      default: return 0;
    endcase
  endfunction

  task automatic start(input int c, input int s, input int p);
    rst = 1'b1;
    core_fac = 3'(c); sync_fac = 3'(s); period_sel = 3'(p);
    repeat (3) @(negedge clk);
    chk(!(core_en | pre_en | rx_en | tx_en), "R9 enables low in reset",
        {core_en, pre_en, rx_en, tx_en}, 0);
    rst = 1'b0;
  endtask

  task automatic sweep(input int c, input int s, input int p, input int len);
    int bad_c = -1, bad_p = -1, bad_r = -1, bad_t = -1;
    bit ac, ap, ar, at, ec, ep, er, et;
    start(c, s, p);
    for (int k = 1; k <= len; k++) begin
      int tk, tp;
      @(negedge clk);
      tk = pre_ticks(s, k);
      tp = pre_ticks(s, k - 1);
      ec = (k % (c + 1)) == 0;
      ep = tk > tp;
      er = ep && (tk % 4) == 0;
      et = ep && (tk % (p + 4)) == 0;
      if (core_en !== ec && bad_c < 0) begin bad_c = k; ac = core_en; end
      if (pre_en  !== ep && bad_p < 0) begin bad_p = k; ap = pre_en;  end
      if (rx_en   !== er && bad_r < 0) begin bad_r = k; ar = rx_en;   end
      if (tx_en   !== et && bad_t < 0) begin bad_t = k; at = tx_en;   end
    end
    chk(bad_c < 0, $sformatf("R1 R10 R9 core_en c=%0d s=%0d edge=%0d", c, s, bad_c), ac, !ac);
    chk(bad_p < 0, $sformatf("R2 R3 R9 pre_en s=%0d edge=%0d", s, bad_p), ap, !ap);
    chk(bad_r < 0, $sformatf("R4 rx_en s=%0d edge=%0d", s, bad_r), ar, !ar);
    chk(bad_t < 0, $sformatf("R5 tx_en s=%0d p=%0d edge=%0d", s, p, bad_t), at, !at);
  endtask

  task automatic tx_rate(input int s, input int p);
    int cnt = 0, first = 0;
    start(0, s, p);
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      if (tx_en) begin cnt++; if (first == 0) first = k; end
    end
    chk(cnt == 10 && first == 8, $sformatf("R6 tx count s=%0d p=%0d", s, p), cnt * 100 + first, 1008);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    for (int s = 0; s < 8; s++) begin
      sync_fac = 3'(s);
      #1;
      chk(cfg_err === (s > 5), $sformatf("R7 cfg_err 40MHz s=%0d", s), cfg_err, s > 5);
      chk(h_err === (s < 2 || s > 5), $sformatf("R7 cfg_err 80MHz s=%0d", s), h_err, s < 2 || s > 5);
    end

    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 8; p++)
        sweep((s * 3 + p) % 8, s, p, 150);

    tx_rate(2, 0);
    tx_rate(0, 4);

    // R8 core: period 4 switched to period 2 after edge 9
    start(3, 0, 0);
    ok = 1'b1;
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      if (k == 9) core_fac = 3'd1;
      if (k >= 10 && core_en !== (k == 12 || k == 14 || k == 16)) ok = 1'b0;
    end
    chk(ok, "R8 core_en reload at terminal", ok, 1);

    // R8 prescaler: divide 2 switched to divide 6 after edge 5
    start(0, 2, 0);
    ok = 1'b1;
    for (int k = 1; k <= 19; k++) begin
      @(negedge clk);
      if (k == 5) sync_fac = 3'd5;
      if (k >= 6 && pre_en !== (k == 6 || k == 12 || k == 18)) ok = 1'b0;
    end
    chk(ok, "R8 pre_en reload at terminal", ok, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule